// File: doc/BRIEF.md
# Cluster Configuration Register Block

This block is the shared configuration register space of a small multi-processor cluster. Every processor in the cluster reaches it over a simple register bus. Each access carries the index of the processor that issued it. The block holds a few cluster-wide registers:

- the relocatable base of the block itself;
- a fixed revision value;
- a base/enable pair for the interrupt controller;
- a base/enable pair for the power controller.

The block also holds one small register set per processor. Each set contains a reset base and a "peer" pointer. The outputs carry the reset vector of every processor and the current base/enable values of the relocatable regions. Address decoding of those regions is left to the surrounding fabric.

The per-processor sets can be reached through two address windows, and each window places the registers at the same offsets:

- The self window always reaches the requester's own set.
- The peer window reaches the set named by the requester's peer pointer. A processor can therefore set up another processor's reset vector before that processor is released from reset.

The peer pointer only accepts indices of processors that exist. The two peripheral base registers can only be written while the matching peripheral reports that it is present.

Top module: `clu_cfg_regs`

## Requirements
- R1: After synchronous reset, the following hold:
  - Every reset vector output is 0xBFC00000 and every peer pointer is 0.
  - Both peripheral base outputs and both enable outputs are 0.
  - The block's own base output is the parameter BASE_RST masked to bits [31:15].
- R2: A read strobe produces `rd_valid_o` high in the next cycle, with `rd_data_o` holding the addressed value. Reads of unimplemented offsets, including any address outside the three windows, return 0.
- R3: The following registers are read-only:
  - Global config (global window, offset 0x000) reads 0.
  - Revision (offset 0x010) reads parameter REV, whose default is 0x800.
  - Cache config (offset 0x038) reads 0x00100000, which is only its bypass bit 20.
  - Per-processor config (offset 0x000 in either processor window) reads NPROC-1.
- R4: A write to a peer pointer (processor-window offset 0x008) masks the data to bits [3:0]. The write takes effect only when that value is less than NPROC; any other write leaves the pointer unchanged.
- R5: The address windows decode from address bits [15:12]:
  - 0x0 is the global window.
  - 0x2 is the self window, which reaches the set of the requester named by `bus_cpu_i`.
  - 0x4 is the peer window, which reaches the set named by the requester's peer pointer.
- R6: A reset-base write (processor-window offset 0x010) stores the data masked to bits [31:12]. The matching 32-bit slice of `rst_vec_o` (processor i at bits [32i+31:32i]) shows the new value in the cycle after the write.
- R7: The interrupt-controller base (offset 0x018) and the power-controller base (offset 0x020) are written only while the matching present input is high. They store bits [31:15] as the address, driven on the base output, and bit 0 as the enable, driven on the enable output. The stored value reads back masked the same way.
- R8: The interrupt-controller status register (offset 0x028) and the power-controller status register (offset 0x030) read 1 when the matching present input is high and 0 otherwise.
- R9: A write to the block's own base (offset 0x008) stores the data masked to bits [31:15]. `cfg_base_o` carries that value, and `cpu_base_o` carries it shifted right by 4.
- R10: Writes to unimplemented offsets and to read-only registers change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_cpu_i | input | IDX_W | Index of the requesting processor |
| intc_present_i | input | 1 | Interrupt controller is present |
| pwr_present_i | input | 1 | Power controller is present |
| rd_data_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| rst_vec_o | output | NPROC*32 | Reset vector of every processor |
| cfg_base_o | output | 32 | Relocated base of this block |
| cpu_base_o | output | 32 | Block base shifted right by 4, for the processors |
| intc_base_o | output | 32 | Interrupt-controller region base |
| intc_en_o | output | 1 | Interrupt-controller region enable |
| pwr_base_o | output | 32 | Power-controller region base |
| pwr_en_o | output | 1 | Power-controller region enable |

## Verification
The assertions take two things about the inputs for granted:
- The requester index on an access always names an existing processor.
- Read and write strobes are never raised in the same cycle.

The bench keeps within both assumptions:
- Its tasks drive only processor indices 0 to 3 with the default count of four.
- Each access task raises exactly one strobe for one cycle, and the strobe is low in the cycles between accesses.
- Present inputs change only between accesses, so the rule that an absent peripheral's register holds its value is checked against a stable condition.

// File: rtl/clu_cfg_pkg.sv
package clu_cfg_pkg;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_GLOBAL,
        WIN_SELF,
        WIN_PEER
    } win_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_GCFG,
        RG_SELFBASE,
        RG_REV,
        RG_INTC,
        RG_PWR,
        RG_INTC_ST,
        RG_PWR_ST,
        RG_CACHE,
        RG_PCFG,
        RG_PEER,
        RG_RBASE
    } reg_e;

    typedef struct packed {
        win_e win;
        reg_e sel;
    } dec_t;

    localparam int          DATA_W       = 32;
    localparam int          PEER_W       = 4;
    localparam int          OFS_W        = 12;
    localparam logic [31:0] WIN_ADDR_MSK = 32'hFFFF_8000;
    localparam logic [31:0] WIN_EN_MSK   = 32'h0000_0001;
    localparam logic [31:0] RBASE_MSK    = 32'hFFFF_F000;
    localparam logic [31:0] RBASE_RST    = 32'hBFC0_0000;
    localparam logic [31:0] CACHE_BYPASS = 32'h0010_0000;

    // window codes in the address bits above the offset
    localparam int WCODE_GLOBAL = 0;
    localparam int WCODE_SELF   = 2;
    localparam int WCODE_PEER   = 4;

    // offsets inside the global window
    localparam logic [OFS_W-1:0] OFS_GCFG     = 12'h000;
    localparam logic [OFS_W-1:0] OFS_SELFBASE = 12'h008;
    localparam logic [OFS_W-1:0] OFS_REV      = 12'h010;
    localparam logic [OFS_W-1:0] OFS_INTC     = 12'h018;
    localparam logic [OFS_W-1:0] OFS_PWR      = 12'h020;
    localparam logic [OFS_W-1:0] OFS_INTC_ST  = 12'h028;
    localparam logic [OFS_W-1:0] OFS_PWR_ST   = 12'h030;
    localparam logic [OFS_W-1:0] OFS_CACHE    = 12'h038;

    // offsets inside either processor window
    localparam logic [OFS_W-1:0] OFS_PCFG  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_PEER  = 12'h008;
    localparam logic [OFS_W-1:0] OFS_RBASE = 12'h010;

    function automatic logic [31:0] mask_region(input logic [31:0] d);
        return d & (WIN_ADDR_MSK | WIN_EN_MSK);
    endfunction

    function automatic logic [31:0] mask_rbase(input logic [31:0] d);
        return d & RBASE_MSK;
    endfunction

endpackage

// File: rtl/clu_cfg_decode.sv
module clu_cfg_decode
    import clu_cfg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int WC_W = ADDR_W - OFS_W;

    logic [WC_W-1:0]  wcode;
    logic [OFS_W-1:0] ofs;

    assign wcode = addr_i[ADDR_W-1:OFS_W];
    assign ofs   = addr_i[OFS_W-1:0];

    always_comb begin
        dec_o.win = WIN_NONE;
        dec_o.sel = RG_NONE;
        if (wcode == WC_W'(WCODE_GLOBAL)) begin
            dec_o.win = WIN_GLOBAL;
            unique case (ofs)
                OFS_GCFG:     dec_o.sel = RG_GCFG;
                OFS_SELFBASE: dec_o.sel = RG_SELFBASE;
                OFS_REV:      dec_o.sel = RG_REV;
                OFS_INTC:     dec_o.sel = RG_INTC;
                OFS_PWR:      dec_o.sel = RG_PWR;
                OFS_INTC_ST:  dec_o.sel = RG_INTC_ST;
                OFS_PWR_ST:   dec_o.sel = RG_PWR_ST;
                OFS_CACHE:    dec_o.sel = RG_CACHE;
                default:      dec_o.sel = RG_NONE;
            endcase
        end else if (wcode == WC_W'(WCODE_SELF) || wcode == WC_W'(WCODE_PEER)) begin
            dec_o.win = (wcode == WC_W'(WCODE_SELF)) ? WIN_SELF : WIN_PEER;
            unique case (ofs)
                OFS_PCFG:  dec_o.sel = RG_PCFG;
                OFS_PEER:  dec_o.sel = RG_PEER;
                OFS_RBASE: dec_o.sel = RG_RBASE;
                default:   dec_o.sel = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/clu_cfg_global.sv
module clu_cfg_global
    import clu_cfg_pkg::*;
#(
    parameter logic [31:0] BASE_RST = 32'h1FBF_8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_i,
    input  reg_e        sel_i,
    input  logic [31:0] wdata_i,
    input  logic        intc_present_i,
    input  logic        pwr_present_i,
    output logic [31:0] self_base_o,
    output logic [31:0] intc_reg_o,
    output logic [31:0] pwr_reg_o
);
    logic wr_self, wr_intc, wr_pwr;

    assign wr_self = wr_i && (sel_i == RG_SELFBASE);
    assign wr_intc = wr_i && (sel_i == RG_INTC) && intc_present_i;
    assign wr_pwr  = wr_i && (sel_i == RG_PWR) && pwr_present_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            self_base_o <= BASE_RST & WIN_ADDR_MSK;
            intc_reg_o  <= '0;
            pwr_reg_o   <= '0;
        end else begin
            if (wr_self) self_base_o <= wdata_i & WIN_ADDR_MSK;
            if (wr_intc) intc_reg_o  <= mask_region(wdata_i);
            if (wr_pwr)  pwr_reg_o   <= mask_region(wdata_i);
        end
    end

    assert_intc_absent_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == RG_INTC && !intc_present_i) |=> $stable(intc_reg_o));
    assert_pwr_absent_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == RG_PWR && !pwr_present_i) |=> $stable(pwr_reg_o));
    assert_self_base_mask_R9: assert property (@(posedge clk) disable iff (rst)
        self_base_o[14:0] == 15'd0);

endmodule

// File: rtl/clu_cfg_proc.sv
module clu_cfg_proc
    import clu_cfg_pkg::*;
#(
    parameter int NPROC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rbase_i,
    input  logic              wr_peer_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rbase_o,
    output logic [PEER_W-1:0] peer_o
);
    localparam logic [PEER_W-1:0] NPROC_L = PEER_W'(NPROC);

    logic [PEER_W-1:0] peer_req;
    logic              peer_ok;

    assign peer_req = wdata_i[PEER_W-1:0];
    assign peer_ok  = peer_req < NPROC_L;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbase_o <= mask_rbase(RBASE_RST);
            peer_o  <= '0;
        end else begin
            if (wr_rbase_i)            rbase_o <= mask_rbase(wdata_i);
            if (wr_peer_i && peer_ok)  peer_o  <= peer_req;
        end
    end

    assert_peer_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        peer_o < NPROC_L);
    assert_peer_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_peer_i && wdata_i[PEER_W-1:0] >= NPROC_L) |=> $stable(peer_o));
    assert_rbase_low_clear_R6: assert property (@(posedge clk) disable iff (rst)
        rbase_o[11:0] == 12'd0);

endmodule

// File: rtl/clu_cfg_regs.sv
module clu_cfg_regs
    import clu_cfg_pkg::*;
#(
    parameter int          NPROC    = 4,
    parameter int          ADDR_W   = 16,
    parameter logic [31:0] REV      = 32'h0000_0800,
    parameter logic [31:0] BASE_RST = 32'h1FBF_8000,
    localparam int         IDX_W    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    input  logic [IDX_W-1:0]    bus_cpu_i,
    input  logic                intc_present_i,
    input  logic                pwr_present_i,
    output logic [31:0]         rd_data_o,
    output logic                rd_valid_o,
    output logic [NPROC*32-1:0] rst_vec_o,
    output logic [31:0]         cfg_base_o,
    output logic [31:0]         cpu_base_o,
    output logic [31:0]         intc_base_o,
    output logic                intc_en_o,
    output logic [31:0]         pwr_base_o,
    output logic                pwr_en_o
);
    localparam logic [31:0] PCFG_VAL = 32'(NPROC - 1);

    dec_t              dec;
    logic [31:0]       self_base, intc_reg, pwr_reg;
    logic [31:0]       rbase_a [NPROC];
    logic [PEER_W-1:0] peer_a  [NPROC];
    logic [IDX_W-1:0]  tgt;
    logic              proc_win;
    logic [31:0]       rd_word;

    clu_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    clu_cfg_global #(.BASE_RST(BASE_RST)) u_glb (
        .clk            (clk),
        .rst            (rst),
        .wr_i           (bus_wr_i && dec.win == WIN_GLOBAL),
        .sel_i          (dec.sel),
        .wdata_i        (bus_wdata_i),
        .intc_present_i (intc_present_i),
        .pwr_present_i  (pwr_present_i),
        .self_base_o    (self_base),
        .intc_reg_o     (intc_reg),
        .pwr_reg_o      (pwr_reg)
    );

    // target set: own set in the self window, pointed-to set in the peer window
    assign proc_win = (dec.win == WIN_SELF) || (dec.win == WIN_PEER);
    assign tgt      = (dec.win == WIN_PEER) ? peer_a[bus_cpu_i][IDX_W-1:0] : bus_cpu_i;

    for (genvar i = 0; i < NPROC; i++) begin : g_proc
        logic hit;
        assign hit = bus_wr_i && proc_win && (tgt == IDX_W'(i));

        clu_cfg_proc #(.NPROC(NPROC)) u_proc (
            .clk        (clk),
            .rst        (rst),
            .wr_rbase_i (hit && dec.sel == RG_RBASE),
            .wr_peer_i  (hit && dec.sel == RG_PEER),
            .wdata_i    (bus_wdata_i),
            .rbase_o    (rbase_a[i]),
            .peer_o     (peer_a[i])
        );

        assign rst_vec_o[i*32 +: 32] = rbase_a[i];
    end

    always_comb begin
        rd_word = '0;
        unique case (dec.sel)
            RG_GCFG:     rd_word = '0;
            RG_SELFBASE: rd_word = self_base;
            RG_REV:      rd_word = REV;
            RG_INTC:     rd_word = intc_reg;
            RG_PWR:      rd_word = pwr_reg;
            RG_INTC_ST:  rd_word = {31'd0, intc_present_i};
            RG_PWR_ST:   rd_word = {31'd0, pwr_present_i};
            RG_CACHE:    rd_word = CACHE_BYPASS;
            RG_PCFG:     rd_word = PCFG_VAL;
            RG_PEER:     rd_word = {{(32-PEER_W){1'b0}}, peer_a[tgt]};
            RG_RBASE:    rd_word = rbase_a[tgt];
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= bus_rd_i;
            if (bus_rd_i) rd_data_o <= rd_word;
        end
    end

    assign cfg_base_o  = self_base;
    assign cpu_base_o  = self_base >> 4;
    assign intc_base_o = intc_reg & WIN_ADDR_MSK;
    assign intc_en_o   = intc_reg[0];
    assign pwr_base_o  = pwr_reg & WIN_ADDR_MSK;
    assign pwr_en_o    = pwr_reg[0];

    assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rd_i |=> rd_valid_o);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> !rd_valid_o);
    assert_requester_range_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i || bus_wr_i) |-> (32'(bus_cpu_i) < NPROC));
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_i && bus_wr_i));

endmodule

// File: tb/clu_cfg_regs_bench.sv
`timescale 1ns/1ps
module clu_cfg_regs_bench;
    localparam int NPROC = 4;
    localparam int ADDR_W = 16;
    localparam int IDX_W = 2;
    localparam logic [31:0] BASE_RST = 32'h1FBF_8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [IDX_W-1:0] bus_cpu = '0;
    logic intc_pr = 1'b0, pwr_pr = 1'b0;
    logic [31:0] rd_data;
    logic rd_valid;
    logic [NPROC*32-1:0] rst_vec;
    logic [31:0] cfg_base, cpu_base, intc_base, pwr_base;
    logic intc_en, pwr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clu_cfg_regs #(.NPROC(NPROC), .ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) u_clu_cfg_regs (
        .clk(clk), .rst(rst),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_cpu_i(bus_cpu),
        .intc_present_i(intc_pr), .pwr_present_i(pwr_pr),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rst_vec_o(rst_vec),
        .cfg_base_o(cfg_base), .cpu_base_o(cpu_base),
        .intc_base_o(intc_base), .intc_en_o(intc_en),
        .pwr_base_o(pwr_base), .pwr_en_o(pwr_en)
    );

    localparam logic [15:0] GLB = 16'h0000, SLF = 16'h2000, PER = 16'h4000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input int cpu);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cpu = IDX_W'(cpu); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input int cpu, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_cpu = IDX_W'(cpu); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        checks++;
        if (rd_valid !== 1'b1) begin
            errors++;
            $display("FAIL R2 valid: actual %0b expected 1", rd_valid);
        end
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < NPROC; i++) chk("R1 reset vector", rst_vec[i*32 +: 32], 32'hBFC0_0000);
        chk("R1 intc base", intc_base, 32'h0);
        chk("R1 enables", {30'd0, intc_en, pwr_en}, 32'h0);
        chk("R1 pwr base", pwr_base, 32'h0);
        chk("R1 self base", cfg_base, 32'h1FBF_8000);
        chk("R1 valid idle", {31'd0, rd_valid}, 32'h0);
        for (int i = 0; i < NPROC; i++) begin
            rd(SLF + 16'h008, i, d);
            chk("R1 peer ptr", d, 32'h0);
        end
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        rd(GLB + 16'h000, 0, d); chk("R3 global config", d, 32'h0);
        rd(GLB + 16'h010, 1, d); chk("R3 revision", d, 32'h800);
        rd(GLB + 16'h038, 2, d); chk("R3 cache config", d, 32'h0010_0000);
        rd(SLF + 16'h000, 3, d); chk("R3 proc config self", d, NPROC - 1);
        rd(PER + 16'h000, 0, d); chk("R3 proc config peer", d, NPROC - 1);
    endtask

    task automatic t_peer_ptr();
        logic [31:0] d;
        wr(SLF + 16'h008, 32'h3, 1);
        rd(SLF + 16'h008, 1, d); chk("R4 accept 3", d, 32'h3);
        wr(SLF + 16'h008, 32'h4, 1);
        rd(SLF + 16'h008, 1, d); chk("R4 reject 4", d, 32'h3);
        wr(SLF + 16'h008, 32'hF, 1);
        rd(SLF + 16'h008, 1, d); chk("R4 reject 15", d, 32'h3);
        wr(SLF + 16'h008, 32'h12, 1);
        rd(SLF + 16'h008, 1, d); chk("R4 mask to 2", d, 32'h2);
    endtask

    task automatic t_windows();
        logic [31:0] d;
        // cpu1 peer pointer is 2 here
        wr(PER + 16'h010, 32'h1234_5678, 1);
        chk("R6 peer rbase vector", rst_vec[2*32 +: 32], 32'h1234_5000);
        chk("R5 own vector untouched", rst_vec[1*32 +: 32], 32'hBFC0_0000);
        rd(SLF + 16'h010, 2, d); chk("R5 target self read", d, 32'h1234_5000);
        rd(PER + 16'h010, 1, d); chk("R5 peer read", d, 32'h1234_5000);
        wr(SLF + 16'h010, 32'hFFFF_FFFF, 0);
        chk("R6 self rbase mask", rst_vec[31:0], 32'hFFFF_F000);
        rd(PER + 16'h008, 1, d); chk("R5 peer ptr of cpu2", d, 32'h0);
        wr(PER + 16'h008, 32'h3, 1);
        rd(SLF + 16'h008, 2, d); chk("R5 cpu2 ptr via peer", d, 32'h3);
        rd(SLF + 16'h008, 1, d); chk("R5 cpu1 ptr kept", d, 32'h2);
        wr(PER + 16'h008, 32'h9, 1);
        rd(SLF + 16'h008, 2, d); chk("R4 peer window reject", d, 32'h3);
    endtask

    task automatic t_periph();
        logic [31:0] d;
        intc_pr = 1'b0; pwr_pr = 1'b0;
        wr(GLB + 16'h018, 32'hFFFF_FFFF, 0);
        chk("R7 intc absent base", intc_base, 32'h0);
        chk("R7 intc absent en", {31'd0, intc_en}, 32'h0);
        rd(GLB + 16'h028, 0, d); chk("R8 intc status 0", d, 32'h0);
        intc_pr = 1'b1;
        wr(GLB + 16'h018, 32'hFFFF_FFFF, 0);
        chk("R7 intc base", intc_base, 32'hFFFF_8000);
        chk("R7 intc en", {31'd0, intc_en}, 32'h1);
        rd(GLB + 16'h018, 0, d); chk("R7 intc readback", d, 32'hFFFF_8001);
        rd(GLB + 16'h028, 0, d); chk("R8 intc status 1", d, 32'h1);
        wr(GLB + 16'h020, 32'h0001_8001, 1);
        chk("R7 pwr absent en", {31'd0, pwr_en}, 32'h0);
        rd(GLB + 16'h030, 1, d); chk("R8 pwr status 0", d, 32'h0);
        pwr_pr = 1'b1;
        wr(GLB + 16'h020, 32'h0001_8001, 1);
        chk("R7 pwr base", pwr_base, 32'h0001_8000);
        chk("R7 pwr en", {31'd0, pwr_en}, 32'h1);
        rd(GLB + 16'h030, 1, d); chk("R8 pwr status 1", d, 32'h1);
        wr(GLB + 16'h020, 32'h0002_0000, 1);
        chk("R7 pwr disable", {31'd0, pwr_en}, 32'h0);
        chk("R7 pwr base moved", pwr_base, 32'h0002_0000);
    endtask

    task automatic t_selfbase();
        logic [31:0] d;
        wr(GLB + 16'h008, 32'hABCD_1234, 2);
        chk("R9 cfg base", cfg_base, 32'hABCD_0000);
        chk("R9 cpu base", cpu_base, 32'h0ABC_D000);
        rd(GLB + 16'h008, 3, d); chk("R9 readback", d, 32'hABCD_0000);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        rd(GLB + 16'h100, 0, d); chk("R2 unimpl global read", d, 32'h0);
        rd(16'h6000, 0, d); chk("R2 outside window read", d, 32'h0);
        rd(SLF + 16'h018, 0, d); chk("R2 unimpl proc read", d, 32'h0);
        wr(SLF + 16'h018, 32'h1, 1);
        wr(GLB + 16'h040, 32'hFFFF_FFFF, 0);
        wr(GLB + 16'h010, 32'h0, 0);
        wr(SLF + 16'h000, 32'h7, 3);
        wr(16'h6008, 32'h1, 1);
        rd(SLF + 16'h008, 1, d); chk("R10 ptr kept", d, 32'h2);
        rd(GLB + 16'h010, 0, d); chk("R10 rev kept", d, 32'h800);
        rd(SLF + 16'h000, 3, d); chk("R10 proc config kept", d, NPROC - 1);
        chk("R10 vector kept", rst_vec[3*32 +: 32], 32'hBFC0_0000);
        chk("R10 self base kept", cfg_base, 32'hABCD_0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_peer_ptr();
        t_windows();
        t_periph();
        t_selfbase();
        t_unimpl();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule